// File: doc/BRIEF.md
# Windowed Remote Word Bridge

This block sits between a CPU load/store port and a serial packet engine that talks to a remote controller. The remote controller holds a small boot ROM and a 64-byte scratch RAM in a 2 KB space. Any CPU access whose address falls inside a 1 MB physical window is claimed. The bridge turns it into one aligned 32-bit word request toward the packet engine. Only the word index, made of address bits 10..2, goes to the engine, so the 2 KB space repeats throughout the window. The bridge does not tell ROM from RAM.

Stores are posted. The CPU is released in the same cycle a store is presented, as long as the single write slot is empty. The store then runs on the serial link in the background. Loads block: the CPU stays stalled until the remote word has come back. A load that arrives while a store is still in flight waits, and it goes on the link only after that store has finished. This gives read-after-write ordering.

When a store finishes, the bridge sends a one-cycle pulse to the interrupt logic. Two status flags show write activity:
- A DMA-style busy flag covers the whole life of a posted store, from acceptance to completion.
- An I/O busy flag covers the time the store occupies the link.

Top module: `remote_word_bridge`

## Requirements
- R1: `cpu_claim` is high exactly when `cpu_valid` is high and `cpu_addr[31:20]` equals 12'h1FC. An unclaimed access never gets `cpu_ready` and never produces a link request.
- R2: Every link request carries `cpu_addr[10:2]` as `link_word`. Address bits 19..11 and 1..0 have no effect, so every 2 KB alias inside the window reaches the same word. While `link_valid` waits for `link_ready`, the request stays stable.
- R3: Writes are forwarded whatever their word index, including indices 0..0x1EF, the ROM part of the space. Each write request shows `link_write`=1 and carries the store data.
- R4: A claimed read sees `cpu_ready` only in a cycle where `cpu_rdata` holds the word returned on `link_rdata` with `link_done`. The read stalls for at least the link latency. Reads show `link_write`=0.
- R5: When no write is pending, `cpu_ready` is high in the first cycle a claimed write is presented, so the write is accepted with no stall.
- R6: While a posted write is pending, no read request appears on the link. A read that follows a write to the same word returns the newly written data.
- R7: While a write is pending, a second claimed write sees `cpu_ready` low. It is accepted only after the first write has completed.
- R8: `wr_irq` is a one-cycle pulse. It is raised in the cycle after the edge where a write's `link_done` is taken, and exactly once per write. Reads never raise it.
- R9: `dma_busy` rises in the cycle after a write is accepted and falls together with the `wr_irq` pulse. `io_busy` is high only while the write occupies the link (from its request to its `link_done`), and only while `dma_busy` is high.
- R10: After a synchronous reset, `cpu_ready`, `link_valid`, `dma_busy`, `io_busy` and `wr_irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_valid | input | 1 | CPU access request present |
| cpu_write | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Physical byte address |
| cpu_wdata | input | 32 | Store data |
| cpu_claim | output | 1 | Access falls inside the window |
| cpu_ready | output | 1 | Access accepted (stores) or completed with data (loads) |
| cpu_rdata | output | 32 | Load data, valid with `cpu_ready` on a load |
| link_valid | output | 1 | Word request toward the packet engine |
| link_write | output | 1 | Request direction, 1 = write |
| link_word | output | 9 | Word index, address bits 10..2 |
| link_wdata | output | 32 | Write data |
| link_ready | input | 1 | Engine takes the request |
| link_done | input | 1 | Engine finished the taken request |
| link_rdata | input | 32 | Returned word, valid with `link_done` on a read |
| dma_busy | output | 1 | Posted write outstanding |
| io_busy | output | 1 | Posted write occupying the link |
| wr_irq | output | 1 | One-cycle write completion pulse |

## Verification
The bench first walks all 512 word indices with posted writes. Each write uses a different alias and junk low address bits, and the pass is repeated for two link latencies. This shows whether the forwarded index ignores the mirroring bits, and whether ROM-region indices are forwarded like RAM ones. Every word is then read back through yet another alias. A wrong index or a stale word shows up as a data mismatch.

Back-to-back writes separate a posted write from a blocking one. A write followed at once by a read of the same word separates correct ordering from a read that overtakes the write. An address outside the window, and a slow engine, show that claiming is correct and that reads stall.

// File: rtl/rbr_pkg.sv
`timescale 1ns/1ps
package rbr_pkg;
    localparam int ADDR_W     = 32;
    localparam int DATA_W     = 32;
    localparam int SPACE_BITS = 11;
    localparam int WORD_BITS  = SPACE_BITS - 2;

    typedef logic [WORD_BITS-1:0] word_idx_t;
    typedef logic [DATA_W-1:0]    data_t;

    typedef struct packed {
        logic      write;
        word_idx_t word;
        data_t     data;
    } link_req_t;

    typedef enum logic [2:0] {
        SEQ_IDLE,
        SEQ_WR_REQ,
        SEQ_WR_WAIT,
        SEQ_RD_REQ,
        SEQ_RD_WAIT,
        SEQ_RD_DONE
    } seq_state_e;

    function automatic word_idx_t word_of(input logic [ADDR_W-1:0] addr);
        return addr[SPACE_BITS-1:2];
    endfunction

    function automatic link_req_t make_req(input logic wr, input word_idx_t w, input data_t d);
        link_req_t r;
        r.write = wr;
        r.word  = w;
        r.data  = d;
        return r;
    endfunction
endpackage

// File: rtl/rbr_window_decode.sv
`timescale 1ns/1ps
module rbr_window_decode
    import rbr_pkg::*;
#(
    parameter logic [ADDR_W-1:0] WIN_BASE = 32'h1FC0_0000,
    parameter int                WIN_LSB  = 20
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output word_idx_t         word
);
    localparam int TAG_W = ADDR_W - WIN_LSB;
    localparam logic [TAG_W-1:0] TAG = WIN_BASE[ADDR_W-1:WIN_LSB];

    logic unused_mirror_bits;

    assign hit  = (addr[ADDR_W-1:WIN_LSB] == TAG);
    assign word = word_of(addr);
    assign unused_mirror_bits = ^{addr[WIN_LSB-1:SPACE_BITS], addr[1:0]};
endmodule

// File: rtl/rbr_post_slot.sv
`timescale 1ns/1ps
module rbr_post_slot
    import rbr_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      load,
    input  link_req_t load_req,
    input  logic      release_slot,
    output logic      full,
    output link_req_t held
);
    always_ff @(posedge clk) begin
        if (rst) begin
            full <= 1'b0;
            held <= '0;
        end else if (load) begin
            full <= 1'b1;
            held <= load_req;
        end else if (release_slot) begin
            full <= 1'b0;
        end
    end
endmodule

// File: rtl/rbr_link_seq.sv
`timescale 1ns/1ps
module rbr_link_seq
    import rbr_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      slot_full,
    input  link_req_t slot_req,
    input  logic      rd_pending,
    input  word_idx_t rd_word,
    input  logic      link_ready,
    input  logic      link_done,
    input  data_t     link_rdata,
    output logic      link_valid,
    output link_req_t link_req,
    output logic      wr_complete,
    output logic      rd_ready,
    output data_t     rd_data,
    output logic      on_link_wr
);
    seq_state_e state, state_nx;
    word_idx_t  rd_word_q;
    data_t      rd_data_q;

    always_comb begin
        state_nx = state;
        case (state)
            SEQ_IDLE: begin
                if (slot_full)       state_nx = SEQ_WR_REQ;
                else if (rd_pending) state_nx = SEQ_RD_REQ;
            end
            SEQ_WR_REQ:  if (link_ready) state_nx = SEQ_WR_WAIT;
            SEQ_WR_WAIT: if (link_done)  state_nx = SEQ_IDLE;
            SEQ_RD_REQ:  if (link_ready) state_nx = SEQ_RD_WAIT;
            SEQ_RD_WAIT: if (link_done)  state_nx = SEQ_RD_DONE;
            SEQ_RD_DONE: state_nx = SEQ_IDLE;
            default:     state_nx = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= SEQ_IDLE;
            rd_word_q <= '0;
            rd_data_q <= '0;
        end else begin
            state <= state_nx;
            if (state == SEQ_IDLE && !slot_full && rd_pending)
                rd_word_q <= rd_word;
            if (state == SEQ_RD_WAIT && link_done)
                rd_data_q <= link_rdata;
        end
    end

    always_comb begin
        link_valid  = 1'b0;
        link_req    = '0;
        wr_complete = 1'b0;
        rd_ready    = 1'b0;
        on_link_wr  = 1'b0;
        case (state)
            SEQ_WR_REQ: begin
                link_valid = 1'b1;
                link_req   = make_req(1'b1, slot_req.word, slot_req.data);
                on_link_wr = 1'b1;
            end
            SEQ_WR_WAIT: begin
                on_link_wr  = 1'b1;
                wr_complete = link_done;
            end
            SEQ_RD_REQ: begin
                link_valid = 1'b1;
                link_req   = make_req(1'b0, rd_word_q, '0);
            end
            SEQ_RD_DONE: rd_ready = 1'b1;
            default: ;
        endcase
    end

    assign rd_data = rd_data_q;
endmodule

// File: rtl/remote_word_bridge.sv
`timescale 1ns/1ps
module remote_word_bridge
    import rbr_pkg::*;
#(
    parameter logic [ADDR_W-1:0] WIN_BASE = 32'h1FC0_0000,
    parameter int                WIN_LSB  = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_valid,
    input  logic              cpu_write,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_claim,
    output logic              cpu_ready,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              link_valid,
    output logic              link_write,
    output logic [WORD_BITS-1:0] link_word,
    output logic [DATA_W-1:0] link_wdata,
    input  logic              link_ready,
    input  logic              link_done,
    input  logic [DATA_W-1:0] link_rdata,
    output logic              dma_busy,
    output logic              io_busy,
    output logic              wr_irq
);
    logic      hit;
    word_idx_t acc_word;
    logic      slot_full;
    link_req_t slot_req;
    logic      wr_accept;
    logic      rd_pending;
    logic      wr_complete;
    logic      rd_ready;
    data_t     rd_data;
    link_req_t link_req;
    logic      irq_q;

    rbr_window_decode #(.WIN_BASE(WIN_BASE), .WIN_LSB(WIN_LSB)) u_dec (
        .addr (cpu_addr),
        .hit  (hit),
        .word (acc_word)
    );

    assign cpu_claim  = cpu_valid & hit;
    assign wr_accept  = cpu_claim & cpu_write & ~slot_full;
    assign rd_pending = cpu_claim & ~cpu_write;

    rbr_post_slot u_slot (
        .clk          (clk),
        .rst          (rst),
        .load         (wr_accept),
        .load_req     (make_req(1'b1, acc_word, cpu_wdata)),
        .release_slot (wr_complete),
        .full         (slot_full),
        .held         (slot_req)
    );

    rbr_link_seq u_seq (
        .clk         (clk),
        .rst         (rst),
        .slot_full   (slot_full),
        .slot_req    (slot_req),
        .rd_pending  (rd_pending),
        .rd_word     (acc_word),
        .link_ready  (link_ready),
        .link_done   (link_done),
        .link_rdata  (link_rdata),
        .link_valid  (link_valid),
        .link_req    (link_req),
        .wr_complete (wr_complete),
        .rd_ready    (rd_ready),
        .rd_data     (rd_data),
        .on_link_wr  (io_busy)
    );

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= wr_complete;
    end

    assign cpu_ready  = cpu_claim & (cpu_write ? ~slot_full : rd_ready);
    assign cpu_rdata  = rd_data;
    assign link_write = link_req.write;
    assign link_word  = link_req.word;
    assign link_wdata = link_req.data;
    assign dma_busy   = slot_full;
    assign wr_irq     = irq_q;
endmodule

// File: rtl/rbr_checker.sv
`timescale 1ns/1ps
module rbr_checker (
    input logic       clk,
    input logic       rst,
    input logic       cpu_valid,
    input logic       cpu_write,
    input logic       cpu_claim,
    input logic       cpu_ready,
    input logic       link_valid,
    input logic       link_write,
    input logic       link_ready,
    input logic [8:0] link_word,
    input logic       dma_busy,
    input logic       io_busy,
    input logic       wr_irq
);
    p_ready_needs_claim_r1: assert property (@(posedge clk) disable iff (rst)
        cpu_ready |-> cpu_claim);

    p_claim_needs_valid_r1: assert property (@(posedge clk) disable iff (rst)
        cpu_claim |-> cpu_valid);

    p_req_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (link_valid && !link_ready) |=> (link_valid && $stable(link_word) && $stable(link_write)));

    p_read_behind_write_r6: assert property (@(posedge clk) disable iff (rst)
        (link_valid && !link_write) |-> !dma_busy);

    p_second_write_stall_r7: assert property (@(posedge clk) disable iff (rst)
        (cpu_valid && cpu_write && dma_busy) |-> !cpu_ready);

    p_irq_single_r8: assert property (@(posedge clk) disable iff (rst)
        wr_irq |=> !wr_irq);

    p_irq_on_busy_fall_r8: assert property (@(posedge clk) disable iff (rst)
        wr_irq |-> $fell(dma_busy));

    p_io_within_dma_r9: assert property (@(posedge clk) disable iff (rst)
        io_busy |-> dma_busy);
endmodule

bind remote_word_bridge rbr_checker u_rbr_checker (
    .clk        (clk),
    .rst        (rst),
    .cpu_valid  (cpu_valid),
    .cpu_write  (cpu_write),
    .cpu_claim  (cpu_claim),
    .cpu_ready  (cpu_ready),
    .link_valid (link_valid),
    .link_write (link_write),
    .link_ready (link_ready),
    .link_word  (link_word),
    .dma_busy   (dma_busy),
    .io_busy    (io_busy),
    .wr_irq     (wr_irq)
);

// File: tb/tb_remote_word_bridge.sv
`timescale 1ns/1ps
module tb_remote_word_bridge;
    logic        clk = 1'b0;
    logic        rst;
    logic        cpu_valid, cpu_write;
    logic [31:0] cpu_addr, cpu_wdata, cpu_rdata;
    logic        cpu_claim, cpu_ready;
    logic        link_valid, link_write, link_ready, link_done;
    logic [8:0]  link_word;
    logic [31:0] link_wdata, link_rdata;
    logic        dma_busy, io_busy, wr_irq;

    always #2.5 clk = ~clk;

    remote_word_bridge dut (
        .clk(clk), .rst(rst),
        .cpu_valid(cpu_valid), .cpu_write(cpu_write), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_claim(cpu_claim), .cpu_ready(cpu_ready),
        .cpu_rdata(cpu_rdata), .link_valid(link_valid), .link_write(link_write),
        .link_word(link_word), .link_wdata(link_wdata), .link_ready(link_ready),
        .link_done(link_done), .link_rdata(link_rdata), .dma_busy(dma_busy),
        .io_busy(io_busy), .wr_irq(wr_irq)
    );

    int checks = 0;
    int errors = 0;
    int lat    = 0;
    int eng_cnt = 0;
    logic [8:0]  eng_word;
    logic        eng_write;
    logic [31:0] eng_wdata;
    logic [31:0] mem [512];
    int irq_cnt = 0;
    int wr_cnt  = 0;
    bit done_flag = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    function automatic logic [31:0] pat(input int w, input int pass);
        return (w * 32'h9E37_79B1) ^ (pass << 28) ^ 32'h0000_5A5A;
    endfunction

    always @(negedge clk) if (!rst && wr_irq) irq_cnt++;

    // remote engine model
    initial begin
        link_ready = 0; link_done = 0; link_rdata = 0;
        for (int i = 0; i < 512; i++) mem[i] = 32'hDEAD_0000 | i;
        forever begin
            @(negedge clk);
            if (!rst && link_valid) begin
                eng_word  = link_word;
                eng_write = link_write;
                eng_wdata = link_wdata;
                eng_cnt++;
                if (!link_write && dma_busy)
                    chk(0, "R6 read issued with write pending", 1, 0);
                link_ready = 1;
                @(negedge clk);
                link_ready = 0;
                repeat (lat) @(negedge clk);
                if (eng_write) mem[eng_word] = eng_wdata;
                else           link_rdata = mem[eng_word];
                link_done = 1;
                @(negedge clk);
                link_done = 0;
            end
        end
    end

    task automatic cpu_wr(input logic [31:0] a, input logic [31:0] d, output int stall);
        stall = 0;
        cpu_valid = 1; cpu_write = 1; cpu_addr = a; cpu_wdata = d;
        forever begin
            #1;
            if (cpu_ready) break;
            @(negedge clk);
            stall++;
        end
        @(posedge clk);
        @(negedge clk);
        cpu_valid = 0;
        wr_cnt++;
    endtask

    task automatic cpu_rd(input logic [31:0] a, output logic [31:0] d, output int stall);
        stall = 0;
        cpu_valid = 1; cpu_write = 0; cpu_addr = a; cpu_wdata = 32'hFFFF_FFFF;
        forever begin
            #1;
            if (cpu_ready) break;
            @(negedge clk);
            stall++;
            if (stall > 1000) break;
        end
        d = cpu_rdata;
        @(posedge clk);
        @(negedge clk);
        cpu_valid = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        int st;
        int c0;
        logic [31:0] rd;
        logic [31:0] a;
        rst = 1; cpu_valid = 0; cpu_write = 0; cpu_addr = 0; cpu_wdata = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        #1;
        // R10 reset state
        chk({cpu_ready, link_valid, dma_busy, io_busy, wr_irq} == 5'b0, "R10 reset outputs",
            {27'b0, cpu_ready, link_valid, dma_busy, io_busy, wr_irq}, 0);

        // R1 outside window
        @(negedge clk);
        c0 = eng_cnt;
        cpu_valid = 1; cpu_write = 0; cpu_addr = 32'h0480_0000;
        #1;
        chk(!cpu_claim, "R1 no claim outside window", cpu_claim, 0);
        repeat (15) @(negedge clk);
        chk(!cpu_ready && eng_cnt == c0, "R1 no ready/no request outside", eng_cnt - c0, 0);
        cpu_write = 1; cpu_addr = 32'h1FB0_0000;
        #1;
        chk(!cpu_claim && !cpu_ready, "R1 write below window ignored", cpu_ready, 0);
        cpu_addr = 32'h1FCF_FFFC;
        #1;
        chk(cpu_claim, "R1 top of window claimed", cpu_claim, 1);
        cpu_valid = 0;
        @(negedge clk);

        // R5 / R9 posted write timing
        lat = 4;
        cpu_valid = 1; cpu_write = 1; cpu_addr = 32'h1FC0_07C0; cpu_wdata = 32'h1234_5678;
        #1;
        chk(cpu_ready, "R5 write accepted at once", cpu_ready, 1);
        @(negedge clk);
        cpu_valid = 0; wr_cnt++;
        chk(dma_busy && !io_busy, "R9 dma_busy after accept", {dma_busy, io_busy}, 2'b10);
        @(negedge clk);
        chk(io_busy && link_valid && link_write, "R9 io_busy on link", io_busy, 1);
        // R7 second write stalls
        cpu_wr(32'h1FC0_07C4, 32'hCAFE_F00D, st);
        chk(st > 0, "R7 second write stalled", st, 1);
        repeat (20) @(negedge clk);
        chk(!dma_busy && !io_busy, "R9 busy cleared", dma_busy, 0);
        chk(mem[9'h1F0] == 32'h1234_5678 && mem[9'h1F1] == 32'hCAFE_F00D, "R3 posted data landed",
            mem[9'h1F1], 32'hCAFE_F00D);
        chk(irq_cnt == wr_cnt, "R8 irq per write", irq_cnt, wr_cnt);

        // Sweep all words, two latencies
        for (int pass = 0; pass < 2; pass++) begin
            lat = (pass == 0) ? 0 : 3;
            for (int w = 0; w < 512; w++) begin
                a = 32'h1FC0_0000 | ((w ^ 9'h155) << 11) | (w << 2) | (w & 3);
                cpu_wr(a, pat(w, pass), st);
                @(negedge clk);
                chk(eng_word == w[8:0] && eng_write, w < 9'h1F0 ? "R3 rom-area write forwarded" : "R2 word index",
                    {22'b0, eng_write, eng_word}, {23'b1, w[8:0]});
            end
            repeat (lat + 6) @(negedge clk);
            chk(irq_cnt == wr_cnt, "R8 irq count after sweep", irq_cnt, wr_cnt);
            c0 = irq_cnt;
            for (int w = 0; w < 512; w++) begin
                a = 32'h1FC0_0000 | (((w + 77) & 511) << 11) | (w << 2) | ((w + 1) & 3);
                cpu_rd(a, rd, st);
                chk(rd == pat(w, pass), "R4 read data", rd, pat(w, pass));
                chk(eng_word == w[8:0] && !eng_write, "R2 read word index", {23'b0, eng_word}, w);
            end
            chk(irq_cnt == c0, "R8 no irq on reads", irq_cnt, c0);
        end

        // R6 read right behind write, several latencies
        for (int l = 0; l < 8; l += 3) begin
            lat = l;
            cpu_wr(32'h1FC0_0014, 32'hA000_0000 | l, st);
            cpu_rd(32'h1FCA_8814, rd, st);
            chk(rd == (32'hA000_0000 | l), "R6 read sees prior write", rd, 32'hA000_0000 | l);
        end

        // R4 stall covers latency
        lat = 10;
        cpu_rd(32'h1FC0_0000, rd, st);
        chk(st >= 10, "R4 read stalls for latency", st, 10);
        chk(rd == pat(0, 1), "R4 slow read data", rd, pat(0, 1));

        repeat (5) @(negedge clk);
        chk(irq_cnt == wr_cnt, "R8 final irq count", irq_cnt, wr_cnt);
        finish_run();
    end
endmodule